// File: doc/BRIEF.md
# Adaptive Dual-Period Self-Refresh Controller

This block sequences row refresh for a DRAM while it sits in self-refresh. During normal operation it notes every row that is opened for a write. When self-refresh begins, it runs a retention check on those rows only, one row at a time, through a request and pass/fail handshake with an external tester. The results go into a per-row weak flag.

After the check, the block refreshes rows at one of two rates. Weak rows are refreshed on every tick of the short refresh clock. Every row, weak or not, is refreshed on every LONG_MULT-th tick. Leaving self-refresh finishes the row in progress, returns the block to idle and forgets which rows were written. The weak flags are kept for the next entry.

Top module: `dual_period_refresh_ctrl`

## Requirements
- R1: After reset, test_req and ref_stb are low and every row's written and weak flags are clear. With nothing written, the first self-refresh session produces no test requests, and its short-only passes strobe no rows.
- R2: A pulse on wr_act while the block is idle marks row wr_row as written. At entry, exactly the written rows are tested and no other row is.
- R3: The block tests the written rows one at a time in ascending address order. test_req stays high, and test_row stays constant, until the cycle in which test_done is high.
- R4: test_done with test_fail=1 sets the weak flag of the row under test. test_done with test_fail=0 clears it. Rows that are not tested keep their flag.
- R5: ref_stb stays low while the test phase is running, and ref_tick pulses during that phase are ignored. The first ref_tick after the test phase ends starts a pass over all rows.
- R6: Ticks accepted after the test phase are numbered from 0. A tick whose number is a multiple of LONG_MULT strobes every row. Any other tick strobes only the weak rows. A pass visits rows in ascending order, at most one strobe per cycle.
- R7: sr_exit finishes the row in progress, which is a pending test handshake or the row being strobed, and then returns the block to idle. No later test request or strobe follows until the next sr_enter.
- R8: Leaving self-refresh clears every written flag, so a following entry with no new writes tests no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_act | input | 1 | Row opened for a write (normal mode) |
| wr_row | input | $clog2(ROWS) | Row address of that write |
| sr_enter | input | 1 | Pulse: enter self-refresh |
| sr_exit | input | 1 | Pulse: leave self-refresh |
| ref_tick | input | 1 | Pulse: one short refresh period elapsed |
| test_done | input | 1 | Tester finished the requested row |
| test_fail | input | 1 | Result qualified by test_done, 1 = weak |
| test_req | output | 1 | Retention test requested |
| test_row | output | $clog2(ROWS) | Row under test |
| ref_stb | output | 1 | Refresh strobe for ref_row |
| ref_row | output | $clog2(ROWS) | Row being refreshed |

## Verification
The bench builds the block with ROWS=16 and LONG_MULT=3. A short pass then takes only a few tens of cycles, so many sessions with several long-period cycles fit in a short run. A multiple that is not a power of two checks that the tick counter wraps correctly rather than relying on bit truncation. The small row count also lets random written sets and pass/fail results cover empty, sparse and dense weak maps, plus rows at both ends of the address range.

// File: rtl/dpr_pkg.sv
// Shared types for the dual-period refresh controller.
// Assumes: nothing; holds only the sequencer state encoding.
package dpr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // normal mode, recording writes
        ST_TSCAN = 3'd1,   // walking rows looking for written ones
        ST_TWAIT = 3'd2,   // test handshake pending on current row
        ST_RWAIT = 3'd3,   // refresh phase, waiting for a tick
        ST_RSCAN = 3'd4    // refresh pass walking the rows
    } dpr_state_t;
endpackage

// File: rtl/dpr_row_status.sv
// Per-row status: a written flag and a weak flag for each row.
// Assumes: at most one weak update per cycle; clr_written wins over a
// same-cycle set, which cannot happen since sets occur only when idle.
module dpr_row_status #(
    parameter int ROWS = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_written,
    input  logic             upd_weak,
    input  logic             upd_val,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_written,
    output logic             rd_weak
);
    logic [ROWS-1:0] written_q;
    logic [ROWS-1:0] weak_q;

    // Written flags: set by write activates, cleared in bulk on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= '0;
        end else if (clr_written) begin
            written_q <= '0;
        end else if (set_wr) begin
            written_q[set_row] <= 1'b1;
        end
    end

    // Weak flags: overwritten by each test result for the tested row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weak_q <= '0;
        end else if (upd_weak) begin
            weak_q[rd_row] <= upd_val;
        end
    end

    // Read port addressed by the shared row pointer.
    always_comb begin
        rd_written = written_q[rd_row];
        rd_weak    = weak_q[rd_row];
    end

    // R4: a test result lands in the weak flag of the row it was taken for.
    p_weak_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_weak |=> weak_q[$past(rd_row)] == $past(upd_val));

    // R8: after a bulk clear no written flag remains.
    p_written_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_written |=> written_q == '0);
endmodule

// File: rtl/dpr_tick_phase.sv
// Counts accepted refresh ticks modulo LONG_MULT; full_now marks the tick
// that must refresh every row.
// Assumes: clr and adv are never high together.
module dpr_tick_phase #(
    parameter int LONG_MULT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic full_now
);
    generate
        if (LONG_MULT <= 1) begin : g_single
            // Every tick is a long-period tick.
            assign full_now = 1'b1;
        end else begin : g_count
            localparam int CNT_W = $clog2(LONG_MULT);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LONG_MULT - 1);
            logic [CNT_W-1:0] cnt_q;

            // Phase counter: restarts at 0 on clr, wraps after LONG_MULT ticks.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q <= '0;
                end else if (adv) begin
                    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
                end
            end

            assign full_now = (cnt_q == '0);

            // R6: the counter never leaves 0..LONG_MULT-1.
            p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CNT_LAST);

            // R5: the first tick after a restart is a full pass.
            p_full_after_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> full_now);
        end
    endgenerate
endmodule

// File: rtl/dpr_sequencer.sv
// Self-refresh sequencer: runs the test walk over written rows, then refresh
// passes on each tick, and handles exit requests.
// Assumes: ref_tick spacing exceeds ROWS+1 cycles (ticks during a pass are
// dropped); test_done is only high while test_req is high.
module dpr_sequencer
    import dpr_pkg::*;
#(
    parameter int ROWS = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_enter,
    input  logic             sr_exit,
    input  logic             ref_tick,
    input  logic             test_done,
    input  logic             test_fail,
    input  logic             rd_written,
    input  logic             rd_weak,
    input  logic             phase_full,
    output logic [ROW_W-1:0] ptr,
    output logic             test_req,
    output logic             ref_stb,
    output logic             clr_written,
    output logic             upd_weak,
    output logic             upd_val,
    output logic             phase_clr,
    output logic             phase_adv
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    dpr_state_t       state_q, state_n;
    logic [ROW_W-1:0] ptr_q, ptr_n;
    logic             full_q, full_n;
    logic             exit_q, exit_n;
    logic             exit_now;
    logic             last_row;

    assign exit_now = sr_exit | exit_q;
    assign last_row = (ptr_q == ROW_LAST);

    // Next-state logic for the test walk, refresh passes and exit.
    always_comb begin
        state_n   = state_q;
        ptr_n     = ptr_q;
        full_n    = full_q;
        upd_weak  = 1'b0;
        phase_clr = 1'b0;
        phase_adv = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_enter) begin
                    state_n = ST_TSCAN;
                    ptr_n   = '0;
                end
            end
            ST_TSCAN: begin
                phase_clr = 1'b1;
                if (exit_now) begin
                    state_n = ST_IDLE;
                end else if (rd_written) begin
                    state_n = ST_TWAIT;
                end else if (last_row) begin
                    state_n = ST_RWAIT;
                end else begin
                    ptr_n = ptr_q + ROW_W'(1);
                end
            end
            ST_TWAIT: begin
                phase_clr = 1'b1;
                if (test_done) begin
                    upd_weak = 1'b1;
                    if (exit_now) begin
                        state_n = ST_IDLE;
                    end else if (last_row) begin
                        state_n = ST_RWAIT;
                    end else begin
                        state_n = ST_TSCAN;
                        ptr_n   = ptr_q + ROW_W'(1);
                    end
                end
            end
            ST_RWAIT: begin
                if (exit_now) begin
                    state_n = ST_IDLE;
                end else if (ref_tick) begin
                    state_n   = ST_RSCAN;
                    ptr_n     = '0;
                    full_n    = phase_full;
                    phase_adv = 1'b1;
                end
            end
            ST_RSCAN: begin
                if (exit_now) begin
                    state_n = ST_IDLE;
                end else if (last_row) begin
                    state_n = ST_RWAIT;
                end else begin
                    ptr_n = ptr_q + ROW_W'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
        exit_n = (state_q != ST_IDLE && state_n != ST_IDLE) ? exit_now : 1'b0;
    end

    // State, pointer, pass kind and pending exit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            full_q  <= 1'b0;
            exit_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            full_q  <= full_n;
            exit_q  <= exit_n;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        ptr         = ptr_q;
        test_req    = (state_q == ST_TWAIT);
        ref_stb     = (state_q == ST_RSCAN) && (full_q || rd_weak);
        upd_val     = test_fail;
        clr_written = (state_q != ST_IDLE) && (state_n == ST_IDLE);
    end

    // R3: a pending request keeps its row until the tester answers.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_done) |=> (test_req && $stable(ptr_q)));

    // R6: a pass advances one row per cycle in ascending order.
    p_pass_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RSCAN && !last_row && !exit_now) |=> ptr_q == $past(ptr_q) + ROW_W'(1));

    // R7: a seen exit request never survives into idle.
    p_exit_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RWAIT && exit_now) |=> state_q == ST_IDLE);
endmodule

// File: rtl/dual_period_refresh_ctrl.sv
// Top of the adaptive dual-period self-refresh controller: ties the row
// status store, the tick phase counter and the sequencer together.
// Assumes: pulses on sr_enter/sr_exit/ref_tick last one cycle; ROWS >= 2.
module dual_period_refresh_ctrl #(
    parameter int ROWS      = 64,
    parameter int LONG_MULT = 4,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_act,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             sr_enter,
    input  logic             sr_exit,
    input  logic             ref_tick,
    input  logic             test_done,
    input  logic             test_fail,
    output logic             test_req,
    output logic [ROW_W-1:0] test_row,
    output logic             ref_stb,
    output logic [ROW_W-1:0] ref_row
);
    logic [ROW_W-1:0] ptr;
    logic             rd_written, rd_weak;
    logic             clr_written, upd_weak, upd_val;
    logic             phase_clr, phase_adv, phase_full;
    logic             idle_wr;

    // Writes are recorded only while no self-refresh session is active.
    assign idle_wr = wr_act && !test_req && !ref_stb && !seq_busy;

    logic seq_busy_q;
    logic seq_busy;
    // Session flag: high from entry until the sequencer returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_written) begin
            seq_busy_q <= 1'b0;
        end else if (sr_enter) begin
            seq_busy_q <= 1'b1;
        end
    end
    assign seq_busy = seq_busy_q;

    dpr_row_status #(.ROWS(ROWS)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wr     (idle_wr),
        .set_row    (wr_row),
        .clr_written(clr_written),
        .upd_weak   (upd_weak),
        .upd_val    (upd_val),
        .rd_row     (ptr),
        .rd_written (rd_written),
        .rd_weak    (rd_weak)
    );

    dpr_tick_phase #(.LONG_MULT(LONG_MULT)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_clr),
        .adv     (phase_adv),
        .full_now(phase_full)
    );

    dpr_sequencer #(.ROWS(ROWS)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_enter   (sr_enter),
        .sr_exit    (sr_exit),
        .ref_tick   (ref_tick),
        .test_done  (test_done),
        .test_fail  (test_fail),
        .rd_written (rd_written),
        .rd_weak    (rd_weak),
        .phase_full (phase_full),
        .ptr        (ptr),
        .test_req   (test_req),
        .ref_stb    (ref_stb),
        .clr_written(clr_written),
        .upd_weak   (upd_weak),
        .upd_val    (upd_val),
        .phase_clr  (phase_clr),
        .phase_adv  (phase_adv)
    );

    assign test_row = ptr;
    assign ref_row  = ptr;

    // R2: only a row recorded as written is ever put under test.
    p_req_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> rd_written);

    // R5: testing and refreshing never overlap.
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_req && ref_stb));

    // R7: an exit seen with no handshake pending silences both outputs next cycle.
    p_exit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_exit && !test_req) |=> (!ref_stb && !test_req));
endmodule

// File: tb/test_dual_period_refresh_ctrl.sv
// Bench: directed corner cases plus seeded random sessions, checked against
// a model of written/weak flags kept in the bench.
module test_dual_period_refresh_ctrl;
    localparam int ROWS  = 16;
    localparam int NMULT = 3;
    localparam int RW    = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_act = 1'b0;
    logic [RW-1:0] wr_row = '0;
    logic          sr_enter = 1'b0;
    logic          sr_exit = 1'b0;
    logic          ref_tick = 1'b0;
    logic          test_done = 1'b0;
    logic          test_fail = 1'b0;
    logic          test_req;
    logic [RW-1:0] test_row;
    logic          ref_stb;
    logic [RW-1:0] ref_row;

    dual_period_refresh_ctrl #(.ROWS(ROWS), .LONG_MULT(NMULT)) i_dual_period_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wr_row(wr_row),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_tick(ref_tick),
        .test_done(test_done), .test_fail(test_fail), .test_req(test_req),
        .test_row(test_row), .ref_stb(ref_stb), .ref_row(ref_row)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [ROWS-1:0] written_m = '0;
    logic [ROWS-1:0] weak_m = '0;
    int              tick_idx = 0;

    int  log_rows [64];
    int  log_cnt = 0;
    int  stab_err = 0;
    int  min_delay = 1;

    logic [ROWS-1:0] seen = '0;
    int  strobes = 0;
    int  order_err = 0;
    int  last_row = -1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Tester model: answers each request after a random delay.
    always begin
        @(negedge clk);
        if (test_req) begin
            int r;
            int d;
            bit f;
            r = int'(test_row);
            if (log_cnt < 64) log_rows[log_cnt] = r;
            log_cnt++;
            d = $urandom_range(min_delay, min_delay + 3);
            repeat (d - 1) @(negedge clk);
            if (int'(test_row) != r || !test_req) stab_err++;
            f = ($urandom_range(0, 2) == 0);
            test_done = 1'b1;
            test_fail = f;
            weak_m[r] = f;
            @(negedge clk);
            test_done = 1'b0;
            test_fail = 1'b0;
        end
    end

    // Strobe monitor: records rows refreshed and checks ascending order.
    always @(negedge clk) begin
        if (ref_stb) begin
            if (last_row >= 0 && int'(ref_row) <= last_row) order_err++;
            seen[ref_row] = 1'b1;
            strobes++;
            last_row = int'(ref_row);
        end
    end

    task automatic pulse_enter();
        sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    endtask

    task automatic pulse_exit();
        sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
        written_m = '0;
    endtask

    task automatic write_row(input int r);
        wr_act = 1'b1; wr_row = RW'(r); @(negedge clk); wr_act = 1'b0;
        written_m[r] = 1'b1;
    endtask

    task automatic clear_mon();
        seen = '0; strobes = 0; order_err = 0; last_row = -1;
    endtask

    // One tick during the refresh phase; compares the pass with the model.
    task automatic tick_and_check(input bool_active);
        logic [ROWS-1:0] exp;
        clear_mon();
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        repeat (ROWS + 4) @(negedge clk);
        if (!bool_active) exp = '0;
        else if (tick_idx % NMULT == 0) exp = '1;
        else exp = weak_m;
        if (bool_active) tick_idx++;
        check(seen == exp && strobes == $countones(exp), "R6 pass row set", seen, exp);
        check(order_err == 0, "R6 ascending order", order_err, 0);
    endtask

    // Enter, let the test walk finish, compare tested rows with written set.
    task automatic enter_and_test();
        int k;
        log_cnt = 0; stab_err = 0;
        pulse_enter();
        repeat (ROWS * 9) @(negedge clk);
        k = 0;
        for (int r = 0; r < ROWS; r++) begin
            if (written_m[r]) begin
                check(k < log_cnt && log_rows[k] == r, "R2 R3 tested row order",
                      (k < log_cnt) ? log_rows[k] : -1, r);
                k++;
            end
        end
        check(log_cnt == k, "R2 test count", log_cnt, k);
        check(stab_err == 0, "R3 request held", stab_err, 0);
        tick_idx = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(!test_req && !ref_stb, "R1 outputs after reset", {test_req, ref_stb}, 0);

        // R1: empty session, first full, then short passes strobe nothing.
        enter_and_test();
        check(log_cnt == 0, "R1 no tests after reset", log_cnt, 0);
        for (int t = 0; t < NMULT + 1; t++) tick_and_check(1'b1);
        pulse_exit();
        repeat (3) @(negedge clk);

        // R5 R7: tick during testing ignored, exit mid-handshake.
        write_row(3); write_row(7); write_row(ROWS - 1);
        log_cnt = 0; min_delay = 5;
        pulse_enter();
        while (log_cnt == 0) @(negedge clk);
        clear_mon();
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        @(negedge clk);
        check(strobes == 0, "R5 no strobe while testing", strobes, 0);
        pulse_exit();
        repeat (ROWS * 9) @(negedge clk);
        check(log_cnt == 1, "R7 handshake finished then idle", log_cnt, 1);
        check(strobes == 0, "R7 no strobes after exit", strobes, 0);
        min_delay = 1;

        // R8 R4: next entry has no written rows; weak of row 3 from last result.
        enter_and_test();
        check(log_cnt == 0, "R8 written cleared by exit", log_cnt, 0);
        for (int t = 0; t < NMULT + 2; t++) tick_and_check(1'b1);   // R4 R5 R6

        // R7: exit in the middle of a full pass.
        pulse_exit();
        enter_and_test();
        clear_mon();
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        pulse_exit();
        repeat (ROWS + 4) @(negedge clk);
        check(strobes > 0 && strobes < ROWS, "R7 pass cut short", strobes, 4);
        tick_and_check(1'b0);   // R7: no refresh after exit

        // Random sessions: R2 R3 R4 R6.
        for (int ep = 0; ep < 8; ep++) begin
            int nw;
            int nt;
            nw = $urandom_range(0, ROWS / 2);
            for (int i = 0; i < nw; i++) write_row($urandom_range(0, ROWS - 1));
            if (ep == 2) begin write_row(0); write_row(ROWS - 1); end
            enter_and_test();
            nt = $urandom_range(1, 2 * NMULT + 1);
            for (int t = 0; t < nt; t++) tick_and_check(1'b1);
            pulse_exit();
            repeat (3) @(negedge clk);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        void'($urandom(32'h5eed));
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule